// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block is the interrupt-control part of a classic byte-wide serial port. Four kinds of event come in from the rest of the port as strobes or levels: a receiver line error, received data waiting (or a receive timeout when the FIFOs are on), an empty transmit holding stage, and a change on the modem control lines. A 4-bit enable register, written by the CPU, picks which of these events may interrupt. The block ranks the enabled pending events and presents the top one as an identification byte. It also drives an internal interrupt line and a host request line. The host request line is qualified by an auxiliary output-enable bit.

The block also owns the transmit-holding-empty flag. In byte mode the flag tracks the single holding register. In FIFO mode it tracks whether the transmit FIFO is empty. While the CPU holds the identification read strobe, the byte it sees does not change. Events that arrive meanwhile are still latched and show up once the read ends. A finished read that showed the transmit-empty cause acknowledges that cause.

Top module: `uart_irq_prio`

## Requirements
- R1: Enable bits are: bit 0 received data (and receive timeout in FIFO mode), bit 1 transmit-holding empty, bit 2 line error, bit 3 modem change. A cause whose enable bit is 0 neither becomes pending nor raises `intr`, and an event seen while disabled is not remembered.
- R2: With several causes pending, the identification byte shows line error first, then received data or timeout, then transmit-holding empty, then modem change.
- R3: Identification bit 0 reads 1 when nothing is pending and 0 when a cause is pending. With nothing pending, bits 3:1 read 000.
- R4: Bits 3:1 encode the shown cause: 011 line error, 010 received data, 110 receive timeout (FIFO mode only, ranked with received data), 001 transmit-holding empty, 000 modem change. Bits 7:6 read 11 in FIFO mode and 00 otherwise, and bits 5:4 read 0.
- R5: While `iir_rd` is high the identification byte holds the value it had when the read began. Events during the read are still latched and appear in the cycle after `iir_rd` falls.
- R6: In byte mode, `thre` goes to 1 on `thr_xfer` and to 0 on `thr_wr`. When both occur in the same cycle, the write wins.
- R7: In FIFO mode, `thre` follows `tx_fifo_empty`, reads 0 in the cycle after any `thr_wr`, and ignores `thr_xfer`.
- R8: `irq` is high exactly when `intr` is high and `aux_out_en` is high.
- R9: Each cause clears in its own way. `lsr_rd` clears the line error. The received-data and timeout levels falling clears those causes. `thr_wr` clears transmit-holding empty. `msr_rd` clears the modem change. A read of the identification byte does not clear any other cause.
- R10: Transmit-holding empty becomes pending when `thre` rises with enable bit 1 set, or when enable bit 1 goes from 0 to 1 while `thre` is 1. It is also cleared when an identification read that showed code 001 ends.
- R11: After reset nothing is pending, the enables are 0, `thre` is 1 and the identification byte reads 0x01 (0xC1 once FIFO mode is on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | FIFOs enabled |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 4 | Enable register write data |
| en_q | output | 4 | Current enable register |
| line_err | input | 1 | Receiver line error strobe |
| lsr_rd | input | 1 | Line status read strobe |
| rx_ready | input | 1 | Received data at or above trigger (level) |
| rx_timeout | input | 1 | Receive timeout condition (level) |
| thr_wr | input | 1 | CPU write to holding register or transmit FIFO |
| thr_xfer | input | 1 | Holding register moved to the shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO empty (level) |
| thre | output | 1 | Transmit-holding empty flag |
| modem_chg | input | 1 | Modem line change strobe |
| msr_rd | input | 1 | Modem status read strobe |
| iir_rd | input | 1 | Identification read in progress |
| iir | output | 8 | Identification byte |
| aux_out_en | input | 1 | Auxiliary output enable for the host request |
| intr | output | 1 | Internal interrupt |
| irq | output | 1 | Host interrupt request |

## Verification
The hardest situation to reach is an identification read that overlaps other activity. A cause must already be shown, a higher cause must arrive while the read strobe is held, and the acknowledgement at the end of the read must act only on the cause that was frozen. The bench holds `iir_rd` across several cycles and fires a line error in the middle of the read. It checks that the frozen byte stays, that the line error appears once the read ends, and that the transmit-empty cause has been acknowledged. A second read, of a modem cause, checks that a read alone does not clear it. A sweep covers every enable value, every mix of the four causes and both modes, and compares the byte and both interrupt lines against an encoding computed in the bench.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       en_wr,
  input  logic [3:0] en_wdata,
  output logic [3:0] en_q,
  input  logic       line_err,
  input  logic       lsr_rd,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       thr_wr,
  input  logic       thr_xfer,
  input  logic       tx_fifo_empty,
  output logic       thre,
  input  logic       modem_chg,
  input  logic       msr_rd,
  input  logic       iir_rd,
  output logic [7:0] iir,
  input  logic       aux_out_en,
  output logic       intr,
  output logic       irq
);

  logic [3:0] en_n;
  logic       thre_n, rd_q, rd_done, thre_ack;
  logic       ls_q, ls_n, rx_q, rx_n, to_q, to_n, tx_q, tx_n, ms_q, ms_n;
  logic [7:0] iir_n;

  assign en_n     = en_wr ? en_wdata : en_q;
  assign rd_done  = rd_q & ~iir_rd;
  assign thre_ack = rd_done & (iir[3:0] == 4'b0010);

  assign thre_n = fifo_mode ? (tx_fifo_empty & ~thr_wr)
                            : (~thr_wr & (thr_xfer | thre));

  assign ls_n = en_n[2] & (line_err | (ls_q & ~lsr_rd));
  assign rx_n = en_n[0] & rx_ready;
  assign to_n = en_n[0] & fifo_mode & rx_timeout;
  assign tx_n = en_n[1] & thre_n & (~thre | ~en_q[1] | (tx_q & ~thre_ack));
  assign ms_n = en_n[3] & (modem_chg | (ms_q & ~msr_rd));

  always_comb begin
    iir_n = {fifo_mode, fifo_mode, 6'b000001};
    if (ls_n)      iir_n[3:0] = 4'b0110;
    else if (rx_n) iir_n[3:0] = 4'b0100;
    else if (to_n) iir_n[3:0] = 4'b1100;
    else if (tx_n) iir_n[3:0] = 4'b0010;
    else if (ms_n) iir_n[3:0] = 4'b0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 4'b0000;
      thre <= 1'b1;
      ls_q <= 1'b0;
      rx_q <= 1'b0;
      to_q <= 1'b0;
      tx_q <= 1'b0;
      ms_q <= 1'b0;
      rd_q <= 1'b0;
      iir  <= 8'h01;
    end else begin
      en_q <= en_n;
      thre <= thre_n;
      ls_q <= ls_n;
      rx_q <= rx_n;
      to_q <= to_n;
      tx_q <= tx_n;
      ms_q <= ms_n;
      rd_q <= iir_rd;
      if (!iir_rd) iir <= iir_n;
    end
  end

  assign intr = ls_q | rx_q | to_q | tx_q | ms_q;
  assign irq  = intr & aux_out_en;

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(iir_rd) |-> $stable(iir));

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iir[0] |-> (iir[3:1] == 3'b000));

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(iir_rd) && ls_q) |-> (iir[3:0] == 4'b0110));

  assert_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[2] |-> !ls_q) and (!en_q[3] |-> !ms_q) and (!en_q[1] |-> !tx_q));

  assert_wr_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(thr_wr) |-> !thre);

  assert_fifo_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fifo_mode) && !$past(tx_fifo_empty)) |-> !thre);

endmodule

// File: tb/sim_uart_irq_prio.sv
`timescale 1ns/100ps
module sim_uart_irq_prio;
  logic       clk = 0, rst_n = 0;
  logic       fifo_mode = 0, en_wr = 0, line_err = 0, lsr_rd = 0, rx_ready = 0;
  logic       rx_timeout = 0, thr_wr = 0, thr_xfer = 0, tx_fifo_empty = 1;
  logic       modem_chg = 0, msr_rd = 0, iir_rd = 0, aux_out_en = 0;
  logic [3:0] en_wdata = 0;
  logic [3:0] en_q;
  logic [7:0] iir;
  logic       thre, intr, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_prio u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .en_wr(en_wr),
    .en_wdata(en_wdata), .en_q(en_q), .line_err(line_err), .lsr_rd(lsr_rd),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_wr(thr_wr),
    .thr_xfer(thr_xfer), .tx_fifo_empty(tx_fifo_empty), .thre(thre),
    .modem_chg(modem_chg), .msr_rd(msr_rd), .iir_rd(iir_rd), .iir(iir),
    .aux_out_en(aux_out_en), .intr(intr), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; fifo_mode = 0; en_wr = 0; line_err = 0; lsr_rd = 0; rx_ready = 0;
    rx_timeout = 0; thr_wr = 0; thr_xfer = 0; tx_fifo_empty = 1; modem_chg = 0;
    msr_rd = 0; iir_rd = 0; aux_out_en = 0; en_wdata = 0;
    tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic set_en(logic [3:0] v);
    en_wr = 1; en_wdata = v; tick(); en_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset();
    chk("R11 iir", iir, 8'h01);
    chk("R11 intr", {7'b0, intr}, 8'h00);
    chk("R11 thre", {7'b0, thre}, 8'h01);
    chk("R11 en", {4'b0, en_q}, 8'h00);

    // R10 enable rising with flag set; R6 write and transfer
    set_en(4'b0010);
    chk("R10 raise on enable", iir, 8'h02);
    thr_wr = 1; tick(); thr_wr = 0;
    chk("R6 write clears thre", {7'b0, thre}, 8'h00);
    chk("R9 write clears cause", iir, 8'h01);
    thr_xfer = 1; tick(); thr_xfer = 0;
    chk("R6 xfer sets thre", {7'b0, thre}, 8'h01);
    chk("R10 raise on thre", iir, 8'h02);
    set_en(4'b0000);
    chk("R1 disable drops", iir, 8'h01);
    set_en(4'b0010);
    chk("R10 re-raise", iir, 8'h02);

    // R5 freeze and R10 read acknowledge
    do_reset();
    set_en(4'b0110);
    chk("R5 before read", iir, 8'h02);
    iir_rd = 1; tick();
    line_err = 1; tick(); line_err = 0; tick();
    chk("R5 frozen", iir, 8'h02);
    chk("R5 event latched", {7'b0, intr}, 8'h01);
    iir_rd = 0; tick();
    chk("R5 appears after read", iir, 8'h06);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R10 read acked thre cause", iir, 8'h01);

    // R9 read of a non-thre cause does not clear it
    do_reset();
    set_en(4'b1000);
    modem_chg = 1; tick(); modem_chg = 0;
    chk("R4 modem code", iir, 8'h00);
    iir_rd = 1; tick(); tick(); iir_rd = 0; tick();
    chk("R9 read keeps modem", iir, 8'h00);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R9 msr read clears", iir, 8'h01);

    // R9 clear chain
    do_reset();
    set_en(4'b1101);
    line_err = 1; rx_ready = 1; modem_chg = 1; tick();
    line_err = 0; modem_chg = 0;
    chk("R2 line first", iir, 8'h06);
    lsr_rd = 1; tick(); lsr_rd = 0;
    chk("R9 lsr clears", iir, 8'h04);
    rx_ready = 0; tick();
    chk("R9 rx level drop", iir, 8'h00);
    msr_rd = 1; tick(); msr_rd = 0;
    chk("R9 all clear", iir, 8'h01);

    // R6 write wins
    do_reset();
    thr_wr = 1; thr_xfer = 1; tick(); thr_wr = 0; thr_xfer = 0;
    chk("R6 write wins", {7'b0, thre}, 8'h00);

    // R7 FIFO mode flag
    do_reset();
    fifo_mode = 1; tick();
    chk("R4 fifo idle", iir, 8'hC1);
    thr_wr = 1; tick(); thr_wr = 0;
    chk("R7 write clears", {7'b0, thre}, 8'h00);
    tx_fifo_empty = 0; tick();
    chk("R7 stays low", {7'b0, thre}, 8'h00);
    thr_xfer = 1; tick(); thr_xfer = 0;
    chk("R7 xfer ignored", {7'b0, thre}, 8'h00);
    tx_fifo_empty = 1; tick();
    chk("R7 empty sets", {7'b0, thre}, 8'h01);

    // R1 disabled event forgotten; R4 timeout ignored outside FIFO mode
    do_reset();
    set_en(4'b0101);
    modem_chg = 1; tick(); modem_chg = 0;
    chk("R1 disabled modem", iir, 8'h01);
    set_en(4'b1101);
    chk("R1 not remembered", iir, 8'h01);
    rx_timeout = 1; tick();
    chk("R4 timeout needs fifo", iir, 8'h01);
    rx_timeout = 0;

    // Sweep: every enable, cause mix and mode
    for (int fm = 0; fm < 2; fm++) begin
      for (int e = 0; e < 16; e++) begin
        for (int p = 0; p < 16; p++) begin
          automatic logic [3:0] ev = 4'(e);
          automatic logic [3:0] pv = 4'(p);
          automatic logic ls, rx, tx, ms, any, ax;
          automatic logic [7:0] exp;
          do_reset();
          fifo_mode = fm[0];
          ax = ^{ev, pv, fm[0]};
          aux_out_en = ax;
          set_en(ev);
          if (!pv[2]) begin
            thr_wr = 1; if (fm[0]) tx_fifo_empty = 0;
            tick(); thr_wr = 0;
          end
          if (pv[0]) begin line_err = 1; tick(); line_err = 0; end
          if (pv[1]) begin if (fm[0]) rx_timeout = 1; else rx_ready = 1; end
          if (pv[3]) begin modem_chg = 1; tick(); modem_chg = 0; end
          tick();
          ls = pv[0] & ev[2]; rx = pv[1] & ev[0];
          tx = pv[2] & ev[1]; ms = pv[3] & ev[3];
          any = ls | rx | tx | ms;
          exp = {fm[0], fm[0], 6'b000000};
          if (ls)      exp[3:0] = 4'b0110;
          else if (rx) exp[3:0] = fm[0] ? 4'b1100 : 4'b0100;
          else if (tx) exp[3:0] = 4'b0010;
          else if (ms) exp[3:0] = 4'b0000;
          else         exp[3:0] = 4'b0001;
          chk("R2 R4 sweep iir", iir, exp);
          chk("R1 sweep intr", {7'b0, intr}, {7'b0, any});
          chk("R8 sweep irq", {7'b0, irq}, {7'b0, any & ax});
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule